// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of a free-running timer count when a chosen event happens on an external pin. The pin is brought into the clock domain by a synchronizer chain. An edge detector and an optional event divider then decide which transitions count as capture events. On each capture the timer count is stored in a capture register and an interrupt request flag is raised. Software clears the flag with a single-cycle strobe. It reads the stored count one byte at a time through a small read port.

Software selects the event type by writing a 4-bit mode code. The divider counter is shared by the divide-by-4 and divide-by-16 settings. It is zeroed only by reset or by leaving capture operation. A direct switch from one divide setting to another keeps the partial count, so the first capture after the switch can come early. Software avoids this by writing the off code between the two settings.

Top module: `icap_unit`

## Requirements
- R1: After reset the flag reads 0, both captured bytes read 0x00, the mode is off (0000) and the divider count is zero.
- R2: Mode 0100 captures on every falling pin edge and mode 0101 on every rising pin edge. The pin passes through two synchronizer flops. The capture register and the flag update on the third rising clock edge after the pin changes, and hold the timer value present just before that edge.
- R3: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. The divider count advances on each rising edge. It fires when the count already equals 3 (or 15) and then returns to 0.
- R4: The read port returns bits 7:0 of the captured value when rd_addr is 0 and bits 15:8 when rd_addr is 1.
- R5: Every capture sets the flag. Only a flag_clr strobe clears it. A later capture overwrites the stored value whether or not it was read.
- R6: When a capture and a flag_clr strobe fall in the same clock cycle, the flag ends set.
- R7: Any mode code outside 0100..0111, including 0000, zeroes the divider count, and pin edges in such a mode change neither the captured value nor the flag.
- R8: A direct write from one capture mode to another keeps the divider count. In the every-edge modes the count is held, not cleared. As a result, the first divided capture after the switch can come after fewer edges than the ratio.
- R9: A new mode code written with mode_we takes effect from the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous external event pin |
| timer_val | input | 16 | Current free-running timer count |
| mode_we | input | 1 | Write strobe for the mode code |
| mode_wdata | input | 4 | Mode code to write |
| flag_clr | input | 1 | Single-cycle software clear of the flag |
| rd_addr | input | 1 | Byte select of the read port |
| rd_data | output | 8 | Selected byte of the captured value |
| irq_flag | output | 1 | Capture interrupt request flag |

## Verification
Pulses of random width and timer values are applied in each of the four capture modes. Every stored byte is compared with a bench model of the divider, which separates edge polarity and divide ratio errors. Mode writes drawn at random, including undefined codes, are mixed with the pulses. This shows whether the divider count survives direct switches and is cleared by non-capture codes. Directed cases test the same-cycle clear against capture, the early capture after a divide-ratio switch, and a clean restart through the off code.

// File: rtl/icap_pkg.sv
// Package: shared mode codes and decode helpers for the input capture unit.
// Assumes a 4-bit mode code; codes 0100..0111 are the capture modes.
package icap_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_OFF    = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_FALL   = 4'b0100;
    localparam logic [MODE_W-1:0] MODE_RISE   = 4'b0101;
    localparam logic [MODE_W-1:0] MODE_RISE4  = 4'b0110;
    localparam logic [MODE_W-1:0] MODE_RISE16 = 4'b0111;

    // True when the code selects one of the capture modes.
    function automatic logic is_capture(input logic [MODE_W-1:0] m);
        return (m[3:2] == 2'b01);
    endfunction

    // True when the code selects a divided rising-edge mode.
    function automatic logic is_divided(input logic [MODE_W-1:0] m);
        return (m == MODE_RISE4) || (m == MODE_RISE16);
    endfunction
endpackage

// File: rtl/icap_edge.sv
// Module: icap_edge
// Synchronizes the asynchronous pin through STAGES flops and flags one-cycle
// rising and falling events by comparing the last stage with its previous value.
// Assumes STAGES >= 2 and a pin held for at least two clock cycles per level.
module icap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain: the first stage samples the pin, the others shift it on.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // One further synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    endgenerate

    // Keep the previous synchronized level for the edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

    // R2: an edge event lasts exactly one cycle.
    a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/icap_prescale.sv
// Module: icap_prescale
// Turns edge events into capture strobes for the selected mode. The divider
// count is shared by the divide-by-4 and divide-by-16 modes. It is zeroed only
// by reset or by a non-capture mode, so it survives a direct ratio change.
// Assumes the mode input is registered.
module icap_prescale #(
    parameter int PS_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [icap_pkg::MODE_W-1:0] mode,
    input  logic                      rise,
    input  logic                      fall,
    output logic                      fire
);
    import icap_pkg::*;

    localparam logic [PS_W-1:0] TERM4  = PS_W'(3);
    localparam logic [PS_W-1:0] TERM16 = PS_W'(15);

    logic [PS_W-1:0] cnt_q;
    logic [PS_W-1:0] term;
    logic            at_term;

    // Pick the terminal count for the active divided mode.
    always_comb begin
        term    = (mode == MODE_RISE16) ? TERM16 : TERM4;
        at_term = (cnt_q == term);
    end

    // Decide whether this cycle's edge is a capture event.
    always_comb begin
        unique case (mode)
            MODE_FALL:               fire = fall;
            MODE_RISE:               fire = rise;
            MODE_RISE4, MODE_RISE16: fire = rise & at_term;
            default:                 fire = 1'b0;
        endcase
    end

    // Divider count: clear outside capture, count rising edges in divided modes.
    always_ff @(posedge clk) begin
        if (!rst_n || !is_capture(mode)) cnt_q <= '0;
        else if (is_divided(mode) && rise) cnt_q <= at_term ? '0 : cnt_q + 1'b1;
    end

    // R7: a non-capture mode leaves the count at zero.
    a_r7_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode) |=> (cnt_q == '0));
    // R3: a divided capture returns the count to zero.
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_divided(mode)) |=> (cnt_q == '0));
    // R8: the every-edge modes hold the shared count.
    a_r8_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_FALL || mode == MODE_RISE) && $stable(mode)) |=> $stable(cnt_q));
endmodule

// File: rtl/icap_latch.sv
// Module: icap_latch
// Holds the captured timer value and the interrupt request flag. A capture
// loads the value and sets the flag. The software clear loses to a capture in
// the same cycle. Assumes fire is a one-cycle strobe.
module icap_latch #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [TMR_W-1:0] timer,
    input  logic             clr,
    output logic [TMR_W-1:0] cap_q,
    output logic             flag_q
);
    // Capture register: overwritten by every capture, no overrun guard.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_q <= '0;
        else if (fire) cap_q <= timer;
    end

    // Interrupt flag: set by capture, cleared by software, capture has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= 1'b0;
        else if (fire) flag_q <= 1'b1;
        else if (clr)  flag_q <= 1'b0;
    end

    // R1: reset empties the flag and the capture register.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!flag_q && cap_q == '0));
    // R2: a capture stores the timer value seen in its cycle.
    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cap_q == $past(timer)));
    // R5: without a capture the stored value does not move.
    a_r5_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cap_q));
    // R5: the flag stays set until software clears it.
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    // R6: capture beats a same-cycle clear.
    a_r6_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr) |=> flag_q);
endmodule

// File: rtl/icap_unit.sv
// Module: icap_unit (top)
// Input capture unit: a mode register, pin synchronizer and edge detector,
// event divider, capture register with flag, and a byte-wide read port.
// Assumes the timer count is synchronous to clk and TMR_W is a multiple of BYTE_W.
module icap_unit #(
    parameter int TMR_W       = 16,
    parameter int BYTE_W      = 8,
    parameter int PS_W        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NBYTES     = TMR_W / BYTE_W,
    localparam int ADDR_W     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pin_in,
    input  logic [TMR_W-1:0]            timer_val,
    input  logic                        mode_we,
    input  logic [icap_pkg::MODE_W-1:0] mode_wdata,
    input  logic                        flag_clr,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]           rd_data,
    output logic                        irq_flag
);
    import icap_pkg::*;

    logic [MODE_W-1:0] mode_q;
    logic              rise, fall, fire;
    logic [TMR_W-1:0]  cap_q;
    logic [BYTE_W-1:0] cap_byte [NBYTES];

    // Mode register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_OFF;
        else if (mode_we) mode_q <= mode_wdata;
    end

    icap_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_in),
        .rise (rise),
        .fall (fall)
    );

    icap_prescale #(.PS_W(PS_W)) u_ps (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode_q),
        .rise (rise),
        .fall (fall),
        .fire (fire)
    );

    icap_latch #(.TMR_W(TMR_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .timer (timer_val),
        .clr   (flag_clr),
        .cap_q (cap_q),
        .flag_q(irq_flag)
    );

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign cap_byte[b] = cap_q[b*BYTE_W +: BYTE_W];
        end
    endgenerate

    // Read port: select one byte of the captured value.
    always_comb begin
        rd_data = cap_byte[rd_addr];
    end

    // R9: a mode write is visible in the following cycle.
    a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_q == $past(mode_wdata)));
    // R7: no capture happens in a non-capture mode.
    a_r7_no_capture_off: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode_q) |=> $stable(cap_q));
endmodule

// File: tb/sim_icap_unit.sv
module sim_icap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] timer_val = '0;
    logic        mode_we = 1'b0;
    logic [3:0]  mode_wdata = '0;
    logic        flag_clr = 1'b0;
    logic [0:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        irq_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model of the expected state.
    logic [3:0]  m_mode = 4'b0000;
    logic [3:0]  m_cnt  = '0;
    logic [15:0] m_cap  = '0;
    logic        m_flag = 1'b0;

    always #4 clk = ~clk;

    icap_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_val(timer_val),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .flag_clr(flag_clr),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_flag(irq_flag)
    );

    function automatic bit cap_mode(input logic [3:0] m);
        return (m >= 4'b0100) && (m <= 4'b0111);
    endfunction

    // Expected capture decision for an edge, per R2, R3, R8.
    function automatic bit model_fires(input logic [3:0] m, input bit rising, input logic [3:0] c);
        if (m == 4'b0100) return !rising;
        if (m == 4'b0101) return rising;
        if (m == 4'b0110) return rising && (c == 4'd3);
        if (m == 4'b0111) return rising && (c == 4'd15);
        return 1'b0;
    endfunction

    task automatic model_edge(input bit rising);
        if (model_fires(m_mode, rising, m_cnt)) begin
            m_cap  = timer_val;
            m_flag = 1'b1;
        end
        if (rising && (m_mode == 4'b0110 || m_mode == 4'b0111))
            m_cnt = model_fires(m_mode, rising, m_cnt) ? 4'd0 : m_cnt + 4'd1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic check_state(input string tag);
        @(negedge clk);
        rd_addr = 1'b0; #1;
        chk({tag, " R4 low byte"}, 32'(rd_data), 32'(m_cap[7:0]));
        rd_addr = 1'b1; #1;
        chk({tag, " R4 high byte"}, 32'(rd_data), 32'(m_cap[15:8]));
        chk({tag, " R5 flag"}, 32'(irq_flag), 32'(m_flag));
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
        m_mode = m;
        if (!cap_mode(m)) m_cnt = 4'd0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_flag = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] t_rise, input logic [15:0] t_fall, input int hi, input int lo);
        @(negedge clk);
        timer_val = t_rise; pin_in = 1'b1; model_edge(1'b1);
        repeat (hi) @(negedge clk);
        timer_val = t_fall; pin_in = 1'b0; model_edge(1'b0);
        repeat (lo) @(negedge clk);
    endtask

    task automatic rpulse();
        pulse(16'($urandom), 16'($urandom), 4 + int'($urandom % 4), 4 + int'($urandom % 4));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        check_state("R1 reset");

        // R7: edges in off mode are ignored.
        pulse(16'h1111, 16'h2222, 5, 5);
        check_state("R7 off mode");

        // R2: rising mode, check exact capture cycle.
        set_mode(4'b0101);
        @(negedge clk);
        timer_val = 16'hA5C3; pin_in = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 no capture before third edge", 32'(irq_flag), 32'd0);
        @(negedge clk);
        chk("R2 flag on third edge", 32'(irq_flag), 32'd1);
        m_cap = 16'hA5C3; m_flag = 1'b1;
        repeat (3) @(negedge clk);
        timer_val = 16'h0F0F; pin_in = 1'b0;
        repeat (5) @(negedge clk);
        check_state("R2 rising");

        // R5: overwrite without read, then clear.
        pulse(16'hBEEF, 16'h0001, 4, 5);
        check_state("R5 overwrite");
        clear_flag();
        check_state("R5 cleared");

        // R2: falling mode.
        set_mode(4'b0100);
        pulse(16'h1234, 16'h5678, 5, 5);
        check_state("R2 falling");

        // R6: clear in the capture cycle.
        clear_flag();
        set_mode(4'b0101);
        @(negedge clk);
        timer_val = 16'h7E57; pin_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        m_cap = 16'h7E57; m_flag = 1'b1;
        repeat (3) @(negedge clk);
        timer_val = 16'h0000; pin_in = 1'b0;
        repeat (5) @(negedge clk);
        check_state("R6 capture wins");

        // R3: divide by 4 from a clean count.
        set_mode(4'b0000);
        set_mode(4'b0110);
        clear_flag();
        for (int i = 0; i < 3; i++) pulse(16'(100 + i), 16'h0, 4, 4);
        check_state("R3 div4 three edges");
        pulse(16'hD4D4, 16'h0, 4, 4);
        check_state("R3 div4 fourth edge");

        // R8: premature capture after direct ratio switch.
        clear_flag();
        set_mode(4'b0000);
        set_mode(4'b0111);
        for (int i = 0; i < 3; i++) pulse(16'(200 + i), 16'h0, 4, 4);
        set_mode(4'b0101);
        pulse(16'h3131, 16'h0, 4, 4);
        clear_flag();
        set_mode(4'b0110);
        pulse(16'hEA71, 16'h0, 4, 4);
        check_state("R8 early capture");
        chk("R8 early flag", 32'(irq_flag), 32'd1);

        // R7: undefined code clears count; R9 takes effect.
        set_mode(4'b1010);
        pulse(16'h9999, 16'h8888, 4, 4);
        check_state("R7 undefined mode");
        set_mode(4'b0111);
        clear_flag();
        for (int i = 0; i < 15; i++) pulse(16'(300 + i), 16'h0, 4, 4);
        check_state("R9 div16 fifteen edges");
        pulse(16'hF16F, 16'h0, 4, 4);
        check_state("R3 div16 sixteenth edge");

        // Constrained random mix.
        for (int it = 0; it < 250; it++) begin
            int sel;
            sel = int'($urandom % 10);
            if (sel == 0) set_mode(4'($urandom));
            else if (sel == 1) set_mode(4'b0100 + 4'($urandom % 4));
            else if (sel == 2) clear_flag();
            else rpulse();
            check_state("R3 R8 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired R1 got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule